// File: doc/BRIEF.md
# Eight-port omega switching network

This block steers up to eight packets per clock from input ports to output ports across three rows of two-by-two switching elements. Fixed perfect-shuffle wiring joins the rows. Each input carries a valid bit, a three-bit destination tag and a payload.

At every row a single destination bit chooses the switch output a packet leaves on, so no central controller is needed. Two packets can ask for the same switch output. In that case the packet on the upper line keeps its path, and the packet on the lower line is discarded and reported as blocked. This makes the network blocking, unlike a full crossbar.

Results are captured in one register stage. Each output port presents a valid bit, the payload and the index of the input it came from, and every input sees a grant or blocked flag. Each switching element has two settings, named STRAIGHT and EXCHANGE. STRAIGHT passes upper to upper and lower to lower; EXCHANGE crosses them. The setting is recomputed every cycle from the packets present, and the block holds no other state.

Top module: `omega_net`

## Requirements
- R1: A synchronous active-high `rst` clears `out_vld`, `grant` and `blocked` to all zeros at the next clock edge.
- R2: All outputs change only at a rising clock edge. They reflect the inputs sampled at the previous edge, a latency of one clock.
- R3: A granted packet from input i with tag d appears on output port d, with its payload and with `out_src` equal to i.
- R4: The identity pattern (input i to output i, all eight valid) is delivered with every grant high and no blocked flag.
- R5: A uniform shift (input i to output (i+k) mod 8, all eight valid) is delivered with every grant high and no blocked flag.
- R6: Line addressing works as follows. The shuffle moves line address a to a rotated left by one bit. Row s, counting from 0 at the inputs, reads tag bit 2-s, where 0 selects the upper (even) output and 1 the lower (odd) one. When both packets at a switch ask for the same output, the upper-line packet wins. The lower packet is dropped, its `blocked` bit is set and its `grant` bit stays low. Example: inputs 0 and 4 both sent to tag 0 give input 0 the grant and input 4 the blocked flag.
- R7: An input whose valid bit is low never takes part in a conflict and never drives an output.
- R8: In every cycle after reset, `grant` and `blocked` are disjoint, and together they equal the input valid mask sampled one edge earlier.
- R9: The number of set `out_vld` bits equals the number of set `grant` bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | N_PORTS | Per-input packet valid |
| in_dst | input | N_PORTS x log2(N_PORTS) | Per-input destination tag |
| in_data | input | N_PORTS x DATA_W | Per-input payload |
| out_vld | output | N_PORTS | Per-output packet valid, registered |
| out_data | output | N_PORTS x DATA_W | Per-output payload, registered |
| out_src | output | N_PORTS x log2(N_PORTS) | Input index that fed each output |
| grant | output | N_PORTS | Per-input delivered flag, registered |
| blocked | output | N_PORTS | Per-input dropped-by-conflict flag, registered |

## Verification
Delivery and conflict loss can occur in the same cycle: one packet wins a switch output and is routed on, while its rival is dropped in the same element. This is provoked by sending two inputs that share a first-row switch to tags with the same top bit. Examples are inputs 0 and 4 toward output 0, and inputs 1 and 5 toward output 7. Each case is judged by checking that the upper-line input alone appears at the output with its own index and payload, that only the lower-line input is flagged, and that the flag counts stay consistent with the sampled valid mask.

// File: rtl/omega_pkg.sv
package omega_pkg;

    typedef enum logic {
        SW_STRAIGHT = 1'b0,
        SW_EXCHANGE = 1'b1
    } sw_state_e;

    // perfect shuffle: rotate a line address left by one bit
    function automatic int shuffle_line(input int idx, input int aw);
        int n;
        n = 1 << aw;
        return ((idx << 1) | (idx >> (aw - 1))) & (n - 1);
    endfunction

endpackage

// File: rtl/omega_switch2.sv
module omega_switch2 #(
    parameter int AW      = 3,
    parameter int DATA_W  = 8,
    parameter int BIT_SEL = 2
) (
    input  logic              up_vld,
    input  logic [AW-1:0]     up_dst,
    input  logic [AW-1:0]     up_src,
    input  logic [DATA_W-1:0] up_data,
    input  logic              lo_vld,
    input  logic [AW-1:0]     lo_dst,
    input  logic [AW-1:0]     lo_src,
    input  logic [DATA_W-1:0] lo_data,
    output logic              o0_vld,
    output logic [AW-1:0]     o0_dst,
    output logic [AW-1:0]     o0_src,
    output logic [DATA_W-1:0] o0_data,
    output logic              o1_vld,
    output logic [AW-1:0]     o1_dst,
    output logic [AW-1:0]     o1_src,
    output logic [DATA_W-1:0] o1_data,
    output logic              lo_drop
);
    import omega_pkg::*;

    sw_state_e state;
    logic      clash;
    logic      lo_keep;

    always_comb begin
        clash   = up_vld && lo_vld && (up_dst[BIT_SEL] == lo_dst[BIT_SEL]);
        lo_keep = lo_vld && !clash;
        lo_drop = clash;
        if (up_vld)
            state = up_dst[BIT_SEL] ? SW_EXCHANGE : SW_STRAIGHT;
        else if (lo_vld)
            state = lo_dst[BIT_SEL] ? SW_STRAIGHT : SW_EXCHANGE;
        else
            state = SW_STRAIGHT;
    end

    always_comb begin
        unique case (state)
            SW_STRAIGHT: begin
                o0_vld = up_vld;  o0_dst = up_dst; o0_src = up_src; o0_data = up_data;
                o1_vld = lo_keep; o1_dst = lo_dst; o1_src = lo_src; o1_data = lo_data;
            end
            SW_EXCHANGE: begin
                o0_vld = lo_keep; o0_dst = lo_dst; o0_src = lo_src; o0_data = lo_data;
                o1_vld = up_vld;  o1_dst = up_dst; o1_src = up_src; o1_data = up_data;
            end
            default: begin
                o0_vld = 1'b0; o0_dst = '0; o0_src = '0; o0_data = '0;
                o1_vld = 1'b0; o1_dst = '0; o1_src = '0; o1_data = '0;
            end
        endcase
    end

endmodule

// File: rtl/omega_stage.sv
module omega_stage #(
    parameter int N      = 8,
    parameter int DATA_W = 8,
    parameter int STAGE  = 0
) (
    input  logic [N-1:0]                    a_vld,
    input  logic [N-1:0][$clog2(N)-1:0]     a_dst,
    input  logic [N-1:0][$clog2(N)-1:0]     a_src,
    input  logic [N-1:0][DATA_W-1:0]        a_data,
    output logic [N-1:0]                    z_vld,
    output logic [N-1:0][$clog2(N)-1:0]     z_dst,
    output logic [N-1:0][$clog2(N)-1:0]     z_src,
    output logic [N-1:0][DATA_W-1:0]        z_data,
    output logic [N-1:0]                    drop_mask
);
    import omega_pkg::*;

    localparam int AW   = $clog2(N);
    localparam int HALF = N / 2;
    localparam int BSEL = AW - 1 - STAGE;

    logic [N-1:0]                s_vld;
    logic [N-1:0][AW-1:0]        s_dst;
    logic [N-1:0][AW-1:0]        s_src;
    logic [N-1:0][DATA_W-1:0]    s_data;
    logic [HALF-1:0]             sw_drop;

    for (genvar j = 0; j < N; j++) begin : g_shuf
        localparam int TGT = shuffle_line(j, AW);
        assign s_vld[TGT]  = a_vld[j];
        assign s_dst[TGT]  = a_dst[j];
        assign s_src[TGT]  = a_src[j];
        assign s_data[TGT] = a_data[j];
    end

    for (genvar k = 0; k < HALF; k++) begin : g_sw
        omega_switch2 #(.AW(AW), .DATA_W(DATA_W), .BIT_SEL(BSEL)) u_sw (
            .up_vld (s_vld[2*k]),   .up_dst (s_dst[2*k]),
            .up_src (s_src[2*k]),   .up_data(s_data[2*k]),
            .lo_vld (s_vld[2*k+1]), .lo_dst (s_dst[2*k+1]),
            .lo_src (s_src[2*k+1]), .lo_data(s_data[2*k+1]),
            .o0_vld (z_vld[2*k]),   .o0_dst (z_dst[2*k]),
            .o0_src (z_src[2*k]),   .o0_data(z_data[2*k]),
            .o1_vld (z_vld[2*k+1]), .o1_dst (z_dst[2*k+1]),
            .o1_src (z_src[2*k+1]), .o1_data(z_data[2*k+1]),
            .lo_drop(sw_drop[k])
        );
    end

    always_comb begin
        drop_mask = '0;
        for (int k = 0; k < HALF; k++)
            if (sw_drop[k]) drop_mask[s_src[2*k+1]] = 1'b1;
    end

endmodule

// File: rtl/omega_net.sv
module omega_net #(
    parameter int N_PORTS = 8,
    parameter int DATA_W  = 8
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic [N_PORTS-1:0]                     in_vld,
    input  logic [N_PORTS-1:0][$clog2(N_PORTS)-1:0] in_dst,
    input  logic [N_PORTS-1:0][DATA_W-1:0]         in_data,
    output logic [N_PORTS-1:0]                     out_vld,
    output logic [N_PORTS-1:0][DATA_W-1:0]         out_data,
    output logic [N_PORTS-1:0][$clog2(N_PORTS)-1:0] out_src,
    output logic [N_PORTS-1:0]                     grant,
    output logic [N_PORTS-1:0]                     blocked
);
    localparam int AW    = $clog2(N_PORTS);
    localparam int N_STG = AW;

    logic [N_STG:0][N_PORTS-1:0]             l_vld;
    logic [N_STG:0][N_PORTS-1:0][AW-1:0]     l_dst;
    logic [N_STG:0][N_PORTS-1:0][AW-1:0]     l_src;
    logic [N_STG:0][N_PORTS-1:0][DATA_W-1:0] l_data;
    logic [N_STG-1:0][N_PORTS-1:0]           stg_drop;
    logic [N_PORTS-1:0]                      blk_c;

    assign l_vld[0]  = in_vld;
    assign l_dst[0]  = in_dst;
    assign l_data[0] = in_data;
    for (genvar i = 0; i < N_PORTS; i++) begin : g_tag
        assign l_src[0][i] = AW'(i);
    end

    for (genvar s = 0; s < N_STG; s++) begin : g_stage
        omega_stage #(.N(N_PORTS), .DATA_W(DATA_W), .STAGE(s)) u_stage (
            .a_vld (l_vld[s]),   .a_dst (l_dst[s]),
            .a_src (l_src[s]),   .a_data(l_data[s]),
            .z_vld (l_vld[s+1]), .z_dst (l_dst[s+1]),
            .z_src (l_src[s+1]), .z_data(l_data[s+1]),
            .drop_mask(stg_drop[s])
        );
    end

    always_comb begin
        blk_c = '0;
        for (int s = 0; s < N_STG; s++) blk_c = blk_c | stg_drop[s];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld  <= '0;
            out_data <= '0;
            out_src  <= '0;
            grant    <= '0;
            blocked  <= '0;
        end else begin
            out_vld  <= l_vld[N_STG];
            out_data <= l_data[N_STG];
            out_src  <= l_src[N_STG];
            grant    <= in_vld & ~blk_c;
            blocked  <= blk_c;
        end
    end

endmodule

// File: rtl/omega_net_chk.sv
module omega_net_chk #(
    parameter int N_PORTS = 8,
    parameter int AW      = 3
) (
    input logic                         clk,
    input logic                         rst,
    input logic [N_PORTS-1:0]           in_vld,
    input logic [N_PORTS-1:0]           out_vld,
    input logic [N_PORTS-1:0][AW-1:0]   out_src,
    input logic [N_PORTS-1:0]           grant,
    input logic [N_PORTS-1:0]           blocked
);
    logic run_q = 1'b0;
    always_ff @(posedge clk) run_q <= !rst;

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (out_vld == '0 && grant == '0 && blocked == '0)); // R1

    AST_FLAGS_DISJOINT: assert property (@(posedge clk) disable iff (rst)
        run_q |-> ((grant & blocked) == '0)); // R8

    AST_FLAGS_COVER_VALID: assert property (@(posedge clk) disable iff (rst)
        run_q |-> ((grant | blocked) == $past(in_vld))); // R8

    AST_DROP_ONLY_VALID: assert property (@(posedge clk) disable iff (rst)
        run_q |-> ((blocked & ~$past(in_vld)) == '0)); // R7

    AST_OUT_COUNT: assert property (@(posedge clk) disable iff (rst)
        run_q |-> ($countones(out_vld) == $countones(grant))); // R9

    for (genvar o = 0; o < N_PORTS; o++) begin : g_src
        AST_SRC_GRANTED: assert property (@(posedge clk) disable iff (rst)
            (run_q && out_vld[o]) |-> grant[out_src[o]]); // R3
    end

endmodule

bind omega_net omega_net_chk #(.N_PORTS(N_PORTS), .AW($clog2(N_PORTS))) u_chk (
    .clk(clk), .rst(rst), .in_vld(in_vld), .out_vld(out_vld),
    .out_src(out_src), .grant(grant), .blocked(blocked)
);

// File: tb/tb_omega_net.sv
`timescale 1ns/1ps
module tb_omega_net;
    localparam int N = 8;
    localparam int AW = 3;
    localparam int DW = 8;

    logic                      clk = 1'b0;
    logic                      rst;
    logic [N-1:0]              in_vld;
    logic [N-1:0][AW-1:0]      in_dst;
    logic [N-1:0][DW-1:0]      in_data;
    logic [N-1:0]              out_vld;
    logic [N-1:0][DW-1:0]      out_data;
    logic [N-1:0][AW-1:0]      out_src;
    logic [N-1:0]              grant;
    logic [N-1:0]              blocked;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    omega_net #(.N_PORTS(N), .DATA_W(DW)) dut (
        .clk(clk), .rst(rst), .in_vld(in_vld), .in_dst(in_dst),
        .in_data(in_data), .out_vld(out_vld), .out_data(out_data),
        .out_src(out_src), .grant(grant), .blocked(blocked)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pay(input int seed, input int i);
        return DW'(seed + i * 17);
    endfunction

    // drive at negedge, wait one rising edge, sample at following negedge
    task automatic drive(input logic [N-1:0] v, input logic [N-1:0][AW-1:0] d,
                         input int seed);
        in_vld = v;
        in_dst = d;
        for (int i = 0; i < N; i++) in_data[i] = pay(seed, i);
        @(negedge clk);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        in_vld = '1; in_dst = '0; in_data = '1;
        repeat (3) @(negedge clk);
        chk("R1", "out_vld", 64'(out_vld), 64'h0);
        chk("R1", "grant",   64'(grant),   64'h0);
        chk("R1", "blocked", 64'(blocked), 64'h0);
        rst = 1'b0;
        in_vld = '0;
        @(negedge clk);
    endtask

    task automatic t_identity;
        logic [N-1:0][AW-1:0] d;
        for (int i = 0; i < N; i++) d[i] = AW'(i);
        in_vld = '1; in_dst = d;
        for (int i = 0; i < N; i++) in_data[i] = pay(3, i);
        #1;
        chk("R2", "out_vld before edge", 64'(out_vld), 64'h0);
        @(negedge clk);
        chk("R4", "grant",   64'(grant),   64'hFF);
        chk("R4", "blocked", 64'(blocked), 64'h0);
        chk("R4", "out_vld", 64'(out_vld), 64'hFF);
        for (int o = 0; o < N; o++) begin
            chk("R3", "identity src",  64'(out_src[o]),  64'(o));
            chk("R3", "identity data", 64'(out_data[o]), 64'(pay(3, o)));
        end
        in_vld = '0;
        #1;
        chk("R2", "hold until edge", 64'(out_vld), 64'hFF);
        @(negedge clk);
        chk("R2", "cleared after edge", 64'(out_vld), 64'h0);
    endtask

    task automatic t_shift(input int k);
        logic [N-1:0][AW-1:0] d;
        for (int i = 0; i < N; i++) d[i] = AW'((i + k) % N);
        drive('1, d, 40 + k);
        chk("R5", "shift grant",   64'(grant),   64'hFF);
        chk("R5", "shift blocked", 64'(blocked), 64'h0);
        chk("R9", "shift out_vld", 64'(out_vld), 64'hFF);
        for (int o = 0; o < N; o++) begin
            chk("R3", "shift src",  64'(out_src[o]),  64'((o - k + N) % N));
            chk("R3", "shift data", 64'(out_data[o]), 64'(pay(40 + k, (o - k + N) % N)));
        end
    endtask

    // two inputs on one first-row switch; upper line wins
    task automatic t_conflict(input int up_in, input int lo_in, input int tag);
        logic [N-1:0][AW-1:0] d;
        logic [N-1:0] v;
        d = '0; v = '0;
        v[up_in] = 1'b1; v[lo_in] = 1'b1;
        d[up_in] = AW'(tag); d[lo_in] = AW'(tag);
        drive(v, d, 90);
        chk("R6", "conflict grant",   64'(grant),   64'(1 << up_in));
        chk("R6", "conflict blocked", 64'(blocked), 64'(1 << lo_in));
        chk("R6", "conflict out_vld", 64'(out_vld), 64'(1 << tag));
        chk("R6", "winner src",  64'(out_src[tag]),  64'(up_in));
        chk("R6", "winner data", 64'(out_data[tag]), 64'(pay(90, up_in)));
        chk("R8", "flags cover", 64'(grant | blocked), 64'(v));
    endtask

    task automatic t_invalid;
        logic [N-1:0][AW-1:0] d;
        d = '0;
        d[4] = 3'd0;
        d[0] = 3'd0;
        drive(8'b0001_0000, d, 120);
        chk("R7", "grant",   64'(grant),   64'h10);
        chk("R7", "blocked", 64'(blocked), 64'h0);
        chk("R7", "out_vld", 64'(out_vld), 64'h01);
        chk("R7", "src",     64'(out_src[0]), 64'd4);
        drive('0, d, 121);
        chk("R7", "idle out_vld", 64'(out_vld), 64'h0);
        chk("R7", "idle flags",   64'(grant | blocked), 64'h0);
    endtask

    initial begin
        @(negedge clk);
        t_reset;
        t_identity;
        t_shift(1);
        t_shift(3);
        t_shift(6);
        t_conflict(0, 4, 0);
        t_conflict(1, 5, 7);
        t_invalid;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule